// File: doc/BRIEF.md
# Edge-Latched Masked Interrupt Controller

This block gathers a group of external interrupt lines, eight by default, into one interrupt request. Each line is brought into the clock domain through a flip-flop synchronizer. A per-line static select input chooses whether a rising or a falling transition counts as an event. When an event is seen on a line, it is captured in that line's latch, but only if the latch is empty. The latch then holds until software removes it by writing a one to that line's bit of the clear register.

The captured bits are ANDed with a software mask to form the pending set. The request output is asserted when the global enable is on and any bit is pending. Pending bits are kept while the enable is off, so a disabled controller does not lose events. A small register port gives software several things: the raw latch state, so it can find events hidden by the mask; the pending set; the mask; a control word with the enable and a summary flag; and an 8-bit vector. The vector is driven onto the read data whenever the acknowledge input is high.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Bit i of `rise_sel` selects the event for input i: 1 means a low-to-high transition and 0 means a high-to-low transition. A transition of the other direction never sets that input's latch.
- R2: With the default two-stage synchronizer, an event on `irq_in` driven just after a falling clock edge is visible in the latch register (address 0) within four clock cycles.
- R3: A set latch bit stays set through further transitions of its input in either direction, until it is cleared.
- R4: Writing the clear register (address 3) clears each latch bit whose written data bit is 1. Bits written as 0 are left as they were. Reading address 3 returns zero.
- R5: The pending register (address 1) reads as the latch register ANDed with the mask register (address 2, read/write). The latch register still shows bits that the mask hides.
- R6: Control register (address 4): bit 0 is the global enable (read/write). Bit 1 is read-only and is 1 exactly when any pending bit is 1, regardless of the enable.
- R7: `irq_req` is 1 exactly when the enable is on and at least one bit is pending. Pending bits survive while the enable is off and drive `irq_req` again once it is back on, unless they were cleared or masked in the meantime.
- R8: The vector register (address 5) is read/write and has no reset value. While `iack` is 1, `rd_data` carries the vector whatever `addr` is.
- R9: Reset clears all latch bits, the mask and the enable, and holds `irq_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Raw external interrupt lines |
| rise_sel | input | 8 | Static per-line event select: 1 = rising, 0 = falling |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| iack | input | 1 | Interrupt acknowledge; puts the vector on `rd_data` |
| rd_data | output | 8 | Register read data, or the vector during acknowledge |
| irq_req | output | 1 | Interrupt request |

## Verification
Each fault in this block shows up at the register port a few cycles after the stimulus that exposes it. A latch that sets on the wrong polarity, or that drops its bit on its own, shows in the latch register four cycles after the input transition. A wrong pending or summary term shows in the first read after a mask or enable write, and a wrong request term shows on `irq_req` in the cycle after that write. Enable is toggled with events pending, and the mask is rewritten while the enable is off, because a controller that loses or invents pending state only shows it there.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_LATCH = 3'd0,
      REG_PEND  = 3'd1,
      REG_MASK  = 3'd2,
      REG_CLEAR = 3'd3,
      REG_CTRL  = 3'd4,
      REG_VECT  = 3'd5
   } reg_sel_e;

   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_ANY_BIT = 1;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] pin_i,
   input  logic [N_LINES-1:0] rise_sel_i,
   output logic [N_LINES-1:0] edge_o
);

   logic [SYNC_STAGES-1:0][N_LINES-1:0] stg_q;
   logic [N_LINES-1:0]                  prev_q;
   logic [N_LINES-1:0]                  cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= stg_q[SYNC_STAGES-1];
      end
   end

   assign cur = stg_q[SYNC_STAGES-1];

   for (genvar i = 0; i < N_LINES; i++) begin : g_pol
      assign edge_o[i] = rise_sel_i[i] ? (cur[i] & ~prev_q[i])
                                       : (~cur[i] & prev_q[i]);
   end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
   parameter int unsigned N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] edge_i,
   input  logic [N_LINES-1:0] clr_i,
   output logic [N_LINES-1:0] latch_o
);

   logic [N_LINES-1:0] latch_q;

   // a bit captures only while empty; a set bit leaves only by a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q & ~clr_i) | (~latch_q & edge_i);
   end

   assign latch_o = latch_q;

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & $past(latch_q & ~clr_i)) == $past(latch_q & ~clr_i)));

   // R1
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_i)) == {N_LINES{1'b0}}));

endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
   import edge_irq_pkg::*;
#(
   parameter int unsigned N_LINES  = 8,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned DATA_W   = 8,
   parameter bit          REQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              iack,
   input  logic [N_LINES-1:0] latch_i,
   output logic [N_LINES-1:0] clr_o,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_req
);

   logic [N_LINES-1:0] mask_q;
   logic [VEC_W-1:0]   vec_q;
   logic               en_q;
   logic [N_LINES-1:0] pend;
   logic               any_pend;
   logic               req_d;
   logic               mask_wr;

   assign mask_wr  = wr_en && (addr == REG_MASK);
   assign pend     = latch_i & mask_q;
   assign any_pend = |pend;
   assign req_d    = en_q & any_pend;
   assign clr_o    = (wr_en && (addr == REG_CLEAR)) ? wr_data[N_LINES-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
      end else if (wr_en) begin
         if (addr == REG_MASK) mask_q <= wr_data[N_LINES-1:0];
         if (addr == REG_CTRL) en_q   <= wr_data[CTRL_EN_BIT];
      end
   end

   // vector has no reset: software programs it before enabling
   always_ff @(posedge clk) begin
      if (wr_en && (addr == REG_VECT)) vec_q <= wr_data[VEC_W-1:0];
   end

   if (REQ_FLOP) begin : g_req_flop
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= req_d;
      end
      assign irq_req = req_q;
   end else begin : g_req_comb
      assign irq_req = req_d;
   end

   always_comb begin
      rd_data = '0;
      if (iack) begin
         rd_data[VEC_W-1:0] = vec_q;
      end else begin
         case (addr)
            REG_LATCH: rd_data[N_LINES-1:0] = latch_i;
            REG_PEND:  rd_data[N_LINES-1:0] = pend;
            REG_MASK:  rd_data[N_LINES-1:0] = mask_q;
            REG_CTRL: begin
               rd_data[CTRL_EN_BIT]  = en_q;
               rd_data[CTRL_ANY_BIT] = any_pend;
            end
            REG_VECT:  rd_data[VEC_W-1:0] = vec_q;
            default:   rd_data = '0;
         endcase
      end
   end

   // R7
   req_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !$past(en_q)) |-> !irq_req);

   // R7
   req_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_req) |-> ($past(wr_en) || $past(wr_en, 2)));

   // R5
   mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mask_wr) |-> $stable(mask_q));

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int unsigned N_INPUTS    = 8,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REQ_FLOP    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_INPUTS-1:0] irq_in,
   input  logic [N_INPUTS-1:0] rise_sel,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                iack,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq_req
);

   if (N_INPUTS < 1 || N_INPUTS > DATA_W) begin : g_bad_inputs
      $error("edge_irq_ctrl: N_INPUTS must be 1..DATA_W");
   end
   if (VEC_W < 1 || VEC_W > DATA_W) begin : g_bad_vec
      $error("edge_irq_ctrl: VEC_W must be 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("edge_irq_ctrl: DATA_W must hold the control bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_INPUTS-1:0] edge_s;
   logic [N_INPUTS-1:0] clr_s;
   logic [N_INPUTS-1:0] latch_s;

   irq_edge_detect #(
      .N_LINES     (N_INPUTS),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (irq_in),
      .rise_sel_i (rise_sel),
      .edge_o     (edge_s)
   );

   irq_latch_bank #(
      .N_LINES (N_INPUTS)
   ) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_i  (edge_s),
      .clr_i   (clr_s),
      .latch_o (latch_s)
   );

   irq_host_regs #(
      .N_LINES  (N_INPUTS),
      .VEC_W    (VEC_W),
      .DATA_W   (DATA_W),
      .REQ_FLOP (REQ_FLOP)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .iack    (iack),
      .latch_i (latch_s),
      .clr_o   (clr_s),
      .rd_data (rd_data),
      .irq_req (irq_req)
   );

   // R9
   req_low_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !irq_req);

endmodule

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = 8'hF0;
   logic [7:0] rise_sel = 8'h0F;   // lines 0-3 rising, 4-7 falling
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic       iack = 1'b0;
   logic [7:0] rd_data;
   logic       irq_req;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   edge_irq_ctrl i_edge_irq_ctrl (
      .clk (clk), .rst_n (rst_n), .irq_in (irq_in), .rise_sel (rise_sel),
      .wr_en (wr_en), .addr (addr), .wr_data (wr_data), .iack (iack),
      .rd_data (rd_data), .irq_req (irq_req)
   );

   localparam logic [2:0] A_LATCH = 3'd0, A_PEND = 3'd1, A_MASK = 3'd2,
                          A_CLR = 3'd3, A_CTRL = 3'd4, A_VEC = 3'd5;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(A_LATCH, v); chk("R9 latch", v, 8'h00);
      rd(A_MASK, v);  chk("R9 mask", v, 8'h00);
      rd(A_CTRL, v);  chk("R9 ctrl", v, 8'h00);
      chk("R9 irq_req", {7'd0, irq_req}, 8'h00);
   endtask

   task automatic t_polarity();
      logic [7:0] v;
      irq_in[0] = 1'b1; irq_in[4] = 1'b0;
      settle();
      rd(A_LATCH, v); chk("R1 R2 rise line0 fall line4", v, 8'h11);
      irq_in[0] = 1'b0; irq_in[4] = 1'b1;
      settle();
      rd(A_LATCH, v); chk("R3 hold on return", v, 8'h11);
      wr(A_CLR, 8'h01);
      rd(A_LATCH, v); chk("R4 clear one bit", v, 8'h10);
      wr(A_CLR, 8'h10);
      rd(A_LATCH, v); chk("R4 clear other bit", v, 8'h00);
      rd(A_CLR, v);   chk("R4 clear reads zero", v, 8'h00);
      irq_in[1] = 1'b1;
      settle();
      wr(A_CLR, 8'h02);
      irq_in[1] = 1'b0;
      settle();
      rd(A_LATCH, v); chk("R1 wrong direction ignored", v, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] v;
      irq_in[2] = 1'b1; settle();
      irq_in[2] = 1'b0; settle();
      irq_in[2] = 1'b1; settle();
      irq_in[2] = 1'b0; settle();
      rd(A_LATCH, v); chk("R3 repeated edges", v, 8'h04);
      wr(A_CLR, 8'h00);
      rd(A_LATCH, v); chk("R4 zero write no effect", v, 8'h04);
   endtask

   task automatic t_pending();
      logic [7:0] v;
      wr(A_MASK, 8'h03);
      rd(A_PEND, v);  chk("R5 masked pending", v, 8'h00);
      rd(A_LATCH, v); chk("R5 latch shows masked", v, 8'h04);
      rd(A_CTRL, v);  chk("R6 none pending", v, 8'h00);
      wr(A_MASK, 8'hFF);
      rd(A_MASK, v);  chk("R5 mask readback", v, 8'hFF);
      rd(A_PEND, v);  chk("R5 unmasked pending", v, 8'h04);
      rd(A_CTRL, v);  chk("R6 any pending while disabled", v, 8'h02);
      chk("R7 no req while disabled", {7'd0, irq_req}, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] v;
      wr(A_VEC, 8'hA5);
      rd(A_VEC, v); chk("R8 vector readback", v, 8'hA5);
      wr(A_CTRL, 8'h01);
      chk("R7 req on enable", {7'd0, irq_req}, 8'h01);
      rd(A_CTRL, v); chk("R6 enable and any", v, 8'h03);
      wr(A_CTRL, 8'h00);
      chk("R7 req off when disabled", {7'd0, irq_req}, 8'h00);
      rd(A_PEND, v); chk("R7 pending kept", v, 8'h04);
      wr(A_CTRL, 8'h01);
      chk("R7 req back on", {7'd0, irq_req}, 8'h01);
      iack = 1'b1;
      rd(A_LATCH, v); chk("R8 vector on iack", v, 8'hA5);
      iack = 1'b0;
      wr(A_CLR, 8'h04);
      chk("R7 req after clear", {7'd0, irq_req}, 8'h00);
      rd(A_CTRL, v); chk("R6 enable only", v, 8'h01);
   endtask

   task automatic t_mask_disabled();
      logic [7:0] v;
      irq_in[6] = 1'b0;
      settle();
      chk("R7 req from line6", {7'd0, irq_req}, 8'h01);
      wr(A_CTRL, 8'h00);
      wr(A_MASK, 8'hBF);
      wr(A_CTRL, 8'h01);
      chk("R7 masked while disabled", {7'd0, irq_req}, 8'h00);
      rd(A_LATCH, v); chk("R5 latch still set", v, 8'h40);
      wr(A_MASK, 8'hFF);
      chk("R7 unmask restores req", {7'd0, irq_req}, 8'h01);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 req in reset", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_polarity();
      t_hold();
      t_pending();
      t_enable();
      t_mask_disabled();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule